// File: doc/BRIEF.md
# SDRAM Bring-up and Refresh Sequencer

This block sits on the controller side of a single-data-rate SDRAM and owns the command bus for two jobs. After reset it walks the memory through its mandatory power-up order: a stabilisation pause with only no-op commands, a precharge of every bank, a programmed number of auto-refresh commands spaced by the row cycle time, and a mode register write. A fixed holdoff follows the mode write, and then the block raises `ready`. `ready` stays high until the next reset.

Once `ready` is high, an interval counter produces one refresh credit per refresh period. By default the period comes from 4096 rows in 64 ms at the configured clock frequency. Credits accumulate in a saturating counter, so requests that come while earlier ones are still waiting are kept, up to a set depth. The block asks the user-traffic arbiter for the bus with `ref_req` and acts only when `ref_grant` is high while it is idle. If the open-bank input shows any bank active at that point, it first precharges all banks and waits the precharge time. It then issues the refresh and holds the bus for the row cycle time. All delays are parameters counted in clock cycles. The command, gap and holdoff parameters must be at least 2.

Top module: `sdram_bringup_refresh`

## Requirements
- R1: For the first PAUSE_CYC cycles after reset is released, the command bus carries no-ops only, with command encoding {cs_n,ras_n,cas_n,we_n} = 4'b0111 and addr = 0. During this time `ready` and `ref_req` are low.
- R2: In cycle PAUSE_CYC after reset release, a precharge-all (encoding 4'b0010) is issued. Its addr has bit 10 set and every other bit clear.
- R3: INIT_REFS auto-refresh commands (encoding 4'b0001) follow. The first comes T_RP cycles after the precharge-all, and each later one comes T_RC cycles after the one before. Every cycle in between carries a no-op.
- R4: One mode register write (encoding 4'b0000) is issued T_RC cycles after the last initial refresh. Its addr is MODE_VALUE with bits 7, 8, 10, 11, 12 and 13 forced to 0. It is never issued again.
- R5: `ready` rises exactly T_MRD cycles after the mode register write, with no-ops in between, and never falls until reset.
- R6: From the cycle `ready` rises, one refresh credit is added every REF_INTERVAL cycles, so `ref_req` first goes high exactly REF_INTERVAL cycles after `ready`. `ref_req` stays high in every cycle in which a credit is outstanding.
- R7: When `ref_grant` is high in a cycle where the block is idle with a credit and open_banks is zero, a refresh appears in the next cycle and consumes one credit. `ref_req` stays high until T_RC cycles after that refresh. Refreshes in normal operation are never closer than T_RC cycles; back-to-back refreshes are T_RC+1 apart.
- R8: When open_banks is nonzero at the granted cycle, a precharge-all (bit 10 set) appears in the next cycle. The refresh follows exactly T_RP cycles after the precharge-all.
- R9: The credit count saturates at MAX_PENDING, and credits beyond it are dropped. With the grant held, exactly MAX_PENDING refreshes drain a saturated backlog.
- R10: `ref_grant` has no effect before `ready` or while no credit is outstanding; the bus then carries no-ops.
- R11: cs_n is always 0, and only the four encodings above ever appear on the command bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Arbiter grants the bus for a refresh |
| open_banks | input | BANKS | One bit per bank, high while that bank has an open row |
| ready | output | 1 | High once the power-up sequence is complete |
| ref_req | output | 1 | Refresh credit outstanding, or refresh still in progress |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: bit 10 on precharge, mode value on mode write |

## Verification
The command bus is decoded straight from the state register. A grant sampled at one rising edge therefore shows its command in the very next cycle, and every later command lands exactly T_RP, T_RC or T_MRD cycles after the one before it. A new credit shows on `ref_req` one cycle after the interval counter reaches its last count, which is REF_INTERVAL cycles after `ready`. The bench counts cycles from reset release and samples on the falling edge. It compares each cycle against an expected timeline built from these offsets, and it tracks credits in its own saturating model. Every refresh is then checked against an outstanding credit, and every precharge against a refresh exactly T_RP cycles later.

// File: rtl/sdram_bringup_refresh.sv
module sdram_bringup_refresh #(
  parameter int ADDR_W       = 14,
  parameter int BANKS        = 4,
  parameter int CLK_MHZ      = 100,
  parameter int ROWS         = 4096,
  parameter int RETENTION_MS = 64,
  parameter int PAUSE_CYC    = 200 * CLK_MHZ,
  parameter int INIT_REFS    = 8,
  parameter int T_RC         = 8,
  parameter int T_RP         = 3,
  parameter int T_MRD        = 3,
  parameter int REF_INTERVAL = (RETENTION_MS * 1000 * CLK_MHZ) / ROWS,
  parameter int MAX_PENDING  = 8,
  parameter logic [ADDR_W-1:0] MODE_VALUE = ADDR_W'(14'h0022)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_grant,
  input  logic [BANKS-1:0]  open_banks,
  output logic              ready,
  output logic              ref_req,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);

  localparam int GMAX1 = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int GMAX2 = (GMAX1 > T_MRD) ? GMAX1 : T_MRD;
  localparam int GMAX  = (GMAX2 > PAUSE_CYC) ? GMAX2 : PAUSE_CYC;
  localparam int GW    = $clog2(GMAX + 1);
  localparam int NW    = $clog2(INIT_REFS + 1);
  localparam int IVW   = $clog2(REF_INTERVAL);
  localparam int PW    = $clog2(MAX_PENDING + 1);

  localparam logic [GW-1:0]     G_PAUSE   = GW'(PAUSE_CYC);
  localparam logic [GW-1:0]     G_RC      = GW'(T_RC - 1);
  localparam logic [GW-1:0]     G_RP      = GW'(T_RP - 1);
  localparam logic [GW-1:0]     G_MRD     = GW'(T_MRD - 1);
  localparam logic [NW-1:0]     LAST_INIT = NW'(INIT_REFS - 1);
  localparam logic [IVW-1:0]    IVL_LAST  = IVW'(REF_INTERVAL - 1);
  localparam logic [PW-1:0]     P_MAX     = PW'(MAX_PENDING);
  localparam logic [ADDR_W-1:0] PRE_ADDR  = ADDR_W'(1 << 10);
  localparam logic [ADDR_W-1:0] MRS_RSVD  = ADDR_W'(14'b11_1101_1000_0000);
  localparam logic [ADDR_W-1:0] MODE_SAFE = MODE_VALUE & ~MRS_RSVD;

  typedef enum logic [2:0] {
    S_GAP, S_PRE_ALL, S_INIT_REF, S_MRS, S_IDLE, S_REF_PRE, S_REF
  } st_t;

  st_t            state, after;
  logic [GW-1:0]  gap;
  logic [NW-1:0]  nref;
  logic [IVW-1:0] ivl;
  logic [PW-1:0]  pending;
  logic           tick, take, is_pre, is_ref, is_mrs;

  assign is_pre = (state == S_PRE_ALL) || (state == S_REF_PRE);
  assign is_ref = (state == S_INIT_REF) || (state == S_REF);
  assign is_mrs = (state == S_MRS);

  assign cs_n  = 1'b0;
  assign ras_n = !(is_pre || is_ref || is_mrs);
  assign cas_n = !(is_ref || is_mrs);
  assign we_n  = !(is_pre || is_mrs);
  assign addr  = is_pre ? PRE_ADDR : (is_mrs ? MODE_SAFE : '0);

  assign tick    = ready && (ivl == IVL_LAST);
  assign take    = (state == S_REF);
  assign ref_req = ready && ((pending != '0) || (state != S_IDLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_GAP;
      after <= S_PRE_ALL;
      gap   <= G_PAUSE;
      nref  <= '0;
      ready <= 1'b0;
    end else begin
      case (state)
        S_GAP: begin
          if (gap == GW'(1)) begin
            state <= after;
            if (after == S_IDLE) ready <= 1'b1;
          end else begin
            gap <= gap - 1'b1;
          end
        end
        S_PRE_ALL: begin
          state <= S_GAP;
          after <= S_INIT_REF;
          gap   <= G_RP;
        end
        S_INIT_REF: begin
          state <= S_GAP;
          gap   <= G_RC;
          nref  <= nref + 1'b1;
          after <= (nref == LAST_INIT) ? S_MRS : S_INIT_REF;
        end
        S_MRS: begin
          state <= S_GAP;
          after <= S_IDLE;
          gap   <= G_MRD;
        end
        S_IDLE: begin
          if ((pending != '0) && ref_grant)
            state <= (|open_banks) ? S_REF_PRE : S_REF;
        end
        S_REF_PRE: begin
          state <= S_GAP;
          after <= S_REF;
          gap   <= G_RP;
        end
        S_REF: begin
          state <= S_GAP;
          after <= S_IDLE;
          gap   <= G_RC;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ivl <= '0;
    else if (ready)
      ivl <= tick ? '0 : ivl + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= '0;
    else if (tick && !take) begin
      if (pending != P_MAX) pending <= pending + 1'b1;
    end else if (take && !tick)
      pending <= pending - 1'b1;
  end

endmodule

module sdram_bringup_refresh_chk #(
  parameter int ADDR_W      = 14,
  parameter int MAX_PENDING = 8,
  parameter int PW          = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              ref_req,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [PW-1:0]     pending
);
  logic [3:0] cmd;
  logic c_nop, c_pre, c_ref, c_mrs;
  assign cmd   = {cs_n, ras_n, cas_n, we_n};
  assign c_nop = (cmd == 4'b0111);
  assign c_pre = (cmd == 4'b0010);
  assign c_ref = (cmd == 4'b0001);
  assign c_mrs = (cmd == 4'b0000);

  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (c_nop || c_pre || c_ref || c_mrs)); // R11
  AST_PRE_A10: assert property (@(posedge clk) disable iff (!rst_n)
    c_pre |-> (addr == ADDR_W'(1 << 10))); // R2
  AST_REF_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    c_ref |=> c_nop); // R3
  AST_MRS_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    c_mrs |-> (addr[13:10] == 4'b0 && addr[8:7] == 2'b0 && !ready)); // R4
  AST_MRS_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    c_mrs |=> (c_nop && !ready)); // R5
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R5
  AST_NO_REQ_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ref_req); // R6
  AST_PENDING_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= PW'(MAX_PENDING)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ref_req) |=> c_nop); // R10
endmodule

bind sdram_bringup_refresh sdram_bringup_refresh_chk #(
  .ADDR_W(ADDR_W), .MAX_PENDING(MAX_PENDING), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .ref_req(ref_req),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .addr(addr), .pending(pending)
);

// File: tb/tb_sdram_bringup_refresh.sv
module tb_sdram_bringup_refresh;
  localparam int TCLK  = 10;
  localparam int PAUSE = 10;
  localparam int NINIT = 8;
  localparam int TRC   = 5;
  localparam int TRP   = 3;
  localparam int TMRD  = 3;
  localparam int RI    = 40;
  localparam int MAXP  = 3;
  localparam logic [13:0] MODE = 14'h3FA2;

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_MRS = 4'b0000;

  localparam int MRS_AT = PAUSE + TRP + NINIT * TRC;
  localparam int R_AT   = MRS_AT + TMRD;
  localparam int G1     = R_AT + 165;
  localparam int IDLE1  = R_AT + 183;
  localparam int G2     = R_AT + 185;
  localparam int PRE2   = R_AT + 201;
  localparam int RND0   = R_AT + 220;
  localparam int RND1   = RND0 + 3000;
  localparam int ENDC   = RND1 + 200;

  logic clk = 1'b0, rst_n = 1'b0, ref_grant = 1'b0;
  logic [3:0] open_banks = 4'b0;
  logic ready, ref_req, cs_n, ras_n, cas_n, we_n;
  logic [13:0] addr;

  always #(TCLK/2) clk = ~clk;

  sdram_bringup_refresh #(
    .ADDR_W(14), .BANKS(4), .PAUSE_CYC(PAUSE), .INIT_REFS(NINIT),
    .T_RC(TRC), .T_RP(TRP), .T_MRD(TMRD), .REF_INTERVAL(RI),
    .MAX_PENDING(MAXP), .MODE_VALUE(MODE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .open_banks(open_banks),
    .ready(ready), .ref_req(ref_req), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] init_cmd(input int c);
    if (c == PAUSE) return C_PRE;
    for (int k = 0; k < NINIT; k++)
      if (c == PAUSE + TRP + k * TRC) return C_REF;
    if (c == MRS_AT) return C_MRS;
    return C_NOP;
  endfunction

  function automatic string init_tag(input int c);
    if (c < PAUSE) return "R1";
    if (c == PAUSE) return "R2";
    if (c < MRS_AT) return "R3";
    if (c == MRS_AT) return "R4";
    return "R5";
  endfunction

  function automatic logic [13:0] mode_expect();
    logic [13:0] v;
    v = MODE;
    v[7] = 1'b0;
    v[8] = 1'b0;
    for (int b = 10; b < 14; b++) v[b] = 1'b0;
    return v;
  endfunction

  initial begin
    #(TCLK * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int mpend, last_ref, last_pre, win_refs;
    bit prev_ref, tick;
    logic [3:0] k, e;
    void'($urandom(32'd20240607));
    mpend = 0; last_ref = -1000; last_pre = -1000; win_refs = 0; prev_ref = 0;
    repeat (3) @(negedge clk);
    check(ready == 1'b0 && ref_req == 1'b0, "R1 reset", {ready, ref_req}, 0);
    rst_n = 1'b1;
    #1;
    for (int c = 0; c <= ENDC; c++) begin
      k = {cs_n, ras_n, cas_n, we_n};
      check(cs_n == 1'b0, "R11 cs_n", cs_n, 0);
      if (c <= R_AT) begin
        e = init_cmd(c);
        check(k == e, init_tag(c), k, e);
        if (e == C_PRE) check(addr == 14'h0400, "R2 addr", addr, 14'h0400);
        if (e == C_MRS) check(addr == mode_expect(), "R4 addr", addr, mode_expect());
        if (e == C_NOP) check(addr == 14'h0, "R1 addr", addr, 0);
        check(ready == (c >= R_AT), "R5 ready", ready, c >= R_AT);
        check(ref_req == 1'b0, "R6 early req", ref_req, 0);
      end else begin
        tick = ((c - R_AT) % RI) == 0;
        mpend = mpend - int'(prev_ref) + int'(tick);
        if (mpend > MAXP) mpend = MAXP;
        check(ready == 1'b1, "R5 sticky", ready, 1);
        check(k == C_NOP || k == C_PRE || k == C_REF, "R11 cmd", k, C_NOP);
        if (c == last_pre + TRP) check(k == C_REF, "R8 pre-to-ref", k, C_REF);
        if (k == C_REF) begin
          check(mpend > 0, "R7 credit", mpend, 1);
          check(c - last_ref >= TRC, "R7 spacing", c - last_ref, TRC);
          last_ref = c;
        end
        if (k == C_PRE) begin
          check(addr == 14'h0400, "R8 addr", addr, 14'h0400);
          last_pre = c;
        end
        if (mpend > 0) check(ref_req == 1'b1, "R6 req", ref_req, 1);
        if (c == R_AT + RI - 1) check(ref_req == 1'b0, "R6 before interval", ref_req, 0);
        if (c == R_AT + RI) check(ref_req == 1'b1, "R6 interval", ref_req, 1);
        if (c >= G1 && c < G1 + 35 && k == C_REF) win_refs++;
        if (c == G1 + 34) check(win_refs == MAXP, "R9 drain", win_refs, MAXP);
        if (c >= IDLE1 && c < R_AT + 200) check(k == C_NOP, "R10 grant idle", k, C_NOP);
        if (c == IDLE1) check(ref_req == 1'b0, "R7 release", ref_req, 0);
        if (c == G1 + 1) check(k == C_REF, "R7 grant", k, C_REF);
        if (c == PRE2) check(k == C_PRE, "R8 open bank", k, C_PRE);
        if (c == PRE2 + TRP) check(k == C_REF, "R8 refresh", k, C_REF);
        prev_ref = (k == C_REF);
      end
      if (c < R_AT) begin
        ref_grant = 1'($urandom % 2);
        open_banks = 4'($urandom);
      end else if (c < G1) begin
        ref_grant = 1'b0;
        open_banks = 4'($urandom);
      end else if (c < G2) begin
        ref_grant = 1'b1;
        open_banks = 4'b0;
      end else if (c < RND0) begin
        ref_grant = 1'b1;
        open_banks = 4'b0100;
      end else if (c < RND1) begin
        ref_grant = (($urandom % 4) == 0);
        open_banks = (($urandom % 2) == 0) ? 4'($urandom) : 4'b0;
      end else begin
        ref_grant = 1'b1;
        open_banks = 4'b0;
      end
      @(negedge clk);
      #1;
    end
    check(mpend == 0 && ref_req == 1'b0, "R9 final drain", mpend, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule